// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is the read front end of a parallel read-only store that holds 16-bit words. A host presents a word address, a width select, an active-low chip select, an active-low output gate and an identifier request. The port answers on a 16-lane output bus with a per-lane drive vector, which stands in for tri-state pins. When the port runs in narrow (8-bit) mode, the topmost lane stops being an output and its level is taken instead as an extra least-significant address bit. That bit picks which half of the stored word goes to lanes 0 to 7.

Access time is modelled in clock cycles. Separate saturating timers run from the last change of the effective address, from the chip-select fall, from the output-gate fall and from the return to wide mode. A group of lanes is flagged valid only when every timer it depends on has expired. Until then the lanes keep their previous value. When either select is released, the valid flags drop at once, and the lanes stop driving after a fixed float delay. When the identifier request is high, the port ignores the array and returns a fixed manufacturer code or device code, picked by address bit 0.

The array is written through a simple load port that a test environment uses to preload contents.

Top module: `byteword_rom_port`

## Requirements
- R1: With `word_sel` high and both selects low, once valid, `q_out[15:0]` equals the stored word, all 16 lanes of `q_drv` are 1, and both `lo_valid` and `hi_valid` are high.
- R2: With `word_sel` low, `lsb_in`=0 puts stored bits 7:0 on `q_out[7:0]` and `lsb_in`=1 puts stored bits 15:8 there. `q_drv[15:8]` is 0, `q_drv[7:0]` is all ones, and `hi_valid` stays low.
- R3: Lanes are driven only while `ce_n` and `oe_n` are both low. Drive starts after the first clock edge that samples both low.
- R4: With `ce_n` high, every lane is undriven once the float delay has passed, whatever `oe_n` does, and both valid flags are low. Out of reset, nothing is driven, both flags are low and `q_out` is 0.
- R5: After the effective address changes, with both selects long settled, `lo_valid` rises on exactly the ACC_CYC-th clock edge counted from the first edge that samples the new address.
- R6: With the address and `ce_n` long settled, `lo_valid` rises on the OE_CYC-th edge counted from the first edge that samples `oe_n` low.
- R7: With the address settled, `lo_valid` rises on the ACC_CYC-th edge counted from the first edge that samples `ce_n` low.
- R8: When `ce_n` or `oe_n` rises, the valid flags drop after the first edge. The lanes stay driven until the FLOAT_CYC-th edge and are undriven from then on.
- R9: While a lane group (7:0 or 15:8) is not valid, its `q_out` value does not change.
- R10: With `id_mode` high, `q_out[7:0]` is 0x20 when `addr[0]`=0 and 0xB1 when `addr[0]`=1, and `q_out[15:8]` is 0x00 in wide mode. This takes priority over the array contents.
- R11: With `id_mode` high, changes on `addr[19:1]` and `lsb_in` neither drop `lo_valid` nor alter `q_out`.
- R12: A change from narrow to wide mode with `lsb_in`=0 keeps `lo_valid` high, and `hi_valid` rises on the BYTE_CYC-th edge after the first edge that samples `word_sel` high. With `lsb_in`=1 the change restarts the address timer instead.
- R13: The load port writes `ld_data` at index `ld_addr`. Reads index the array with the low log2(MEM_WORDS) address bits, so addresses that differ only above those bits return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | 16 | Preload word |
| addr | input | 20 | Word address |
| lsb_in | input | 1 | Extra low address bit, used in narrow mode |
| word_sel | input | 1 | 1 = 16-bit output, 0 = 8-bit output |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| id_mode | input | 1 | Identifier code request |
| q_out | output | 16 | Output lanes |
| q_drv | output | 16 | Per-lane drive enable |
| lo_valid | output | 1 | Lanes 7:0 hold valid data |
| hi_valid | output | 1 | Lanes 15:8 hold valid data |

## Verification
Two of the block's functions can land in the same cycle. In one case the width switch and the low-lane access timing coincide: the bench holds a narrow-mode read valid and then raises `word_sel` in a single cycle. It then judges every cycle until the upper lanes go valid, requiring that the lower lanes never lose validity when the low half was selected, and that they restart when the high half was. In the other case an identifier read overlaps an address change: the bench moves the upper address bits and the extra low bit while a code is being shown. The code and its valid flag must hold through that change, and leaving identifier mode must then cost one full access time.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

    localparam int WADDR_W = 20;

    localparam logic [7:0] MFR_CODE = 8'h20;
    localparam logic [7:0] DEV_CODE = 8'hB1;

    typedef enum logic [1:0] {
        TMR_ADDR = 2'd0,
        TMR_CHIP = 2'd1,
        TMR_GATE = 2'd2,
        TMR_WIDE = 2'd3
    } timer_e;

    localparam int NUM_TMR = 4;

    typedef struct packed {
        logic               id;
        logic               lsb;
        logic [WADDR_W-1:0] addr;
    } sel_key_t;

    function automatic logic [7:0] id_code(input logic a0);
        return a0 ? DEV_CODE : MFR_CODE;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_delay_ctr.sv
module rom_delay_ctr #(
    parameter int LIMIT = 100,
    parameter int CNT_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_zero,
    input  logic kick,
    output logic done
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            cnt <= '0;
        end else if (kick) begin
            cnt <= CNT_W'(1);
        end else if (cnt < LIM) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign done = (cnt >= LIM);
endmodule

// File: rtl/rom_array.sv
module rom_array #(
    parameter int MEM_WORDS = 256,
    parameter int MEM_AW    = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [15:0]       wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [15:0]       rdata
);
    logic [15:0] store [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
    import rom_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] rdata,
    input  logic        id,
    input  logic        a0,
    input  logic        lsb,
    input  logic        lo_ok,
    input  logic        hi_ok,
    output logic [15:0] q
);
    logic [15:0] fresh;
    logic [7:0]  lo_new, hi_new;
    logic [7:0]  lo_hold, hi_hold;

    always_comb begin
        fresh  = id ? {8'h00, id_code(a0)} : rdata;
        lo_new = lsb ? fresh[15:8] : fresh[7:0];
        hi_new = fresh[15:8];
        q      = {hi_ok ? hi_new : hi_hold, lo_ok ? lo_new : lo_hold};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold <= '0;
            hi_hold <= '0;
        end else begin
            lo_hold <= q[7:0];
            hi_hold <= q[15:8];
        end
    end

    assert_lo_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !lo_ok |-> $stable(q[7:0]));
    assert_hi_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !hi_ok |-> $stable(q[15:8]));
endmodule

// File: rtl/byteword_rom_port.sv
module byteword_rom_port
    import rom_port_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int ACC_CYC   = 100,
    parameter int OE_CYC    = 50,
    parameter int BYTE_CYC  = 100,
    parameter int FLOAT_CYC = 3,
    localparam int MEM_AW   = $clog2(MEM_WORDS),
    localparam int CNT_MAX  = max2(max2(ACC_CYC, OE_CYC), BYTE_CYC),
    localparam int CNT_W    = $clog2(CNT_MAX + 1),
    localparam int FLT_W    = $clog2(FLOAT_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_we,
    input  logic [MEM_AW-1:0]  ld_addr,
    input  logic [15:0]        ld_data,
    input  logic [WADDR_W-1:0] addr,
    input  logic               lsb_in,
    input  logic               word_sel,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               id_mode,
    output logic [15:0]        q_out,
    output logic [15:0]        q_drv,
    output logic               lo_valid,
    output logic               hi_valid
);
    sel_key_t           key_d, key_q;
    logic               key_chg;
    logic               word_q;
    logic [FLT_W-1:0]   flt;
    logic [NUM_TMR-1:0] hz, kk, done_v;
    logic [15:0]        rdata;

    // Effective selection: identifier mode keeps only address bit 0
    always_comb begin
        key_d    = '0;
        key_d.id = id_mode;
        if (id_mode) begin
            key_d.addr[0] = addr[0];
        end else begin
            key_d.lsb  = word_sel ? 1'b0 : lsb_in;
            key_d.addr = addr;
        end
        key_chg = (key_d != key_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            word_q <= 1'b0;
            flt    <= '0;
        end else begin
            key_q  <= key_d;
            word_q <= word_sel;
            if (!ce_n && !oe_n)  flt <= FLT_W'(FLOAT_CYC);
            else if (flt != '0)  flt <= flt - FLT_W'(1);
        end
    end

    always_comb begin
        hz           = '0;
        kk           = '0;
        kk[TMR_ADDR] = key_chg;
        hz[TMR_CHIP] = ce_n;
        hz[TMR_GATE] = oe_n;
        hz[TMR_WIDE] = !word_sel;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        rom_delay_ctr #(
            .LIMIT((g == int'(TMR_GATE)) ? OE_CYC :
                   (g == int'(TMR_WIDE)) ? BYTE_CYC : ACC_CYC),
            .CNT_W(CNT_W)
        ) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .hold_zero(hz[g]),
            .kick     (kk[g]),
            .done     (done_v[g])
        );
    end

    assign lo_valid = done_v[TMR_ADDR] & done_v[TMR_CHIP] & done_v[TMR_GATE];
    assign hi_valid = lo_valid & done_v[TMR_WIDE];
    assign q_drv    = (flt != '0) ? {(word_q ? 8'hFF : 8'h00), 8'hFF} : 16'h0000;

    rom_array #(.MEM_WORDS(MEM_WORDS), .MEM_AW(MEM_AW)) u_array (
        .clk  (clk),
        .we   (ld_we),
        .waddr(ld_addr),
        .wdata(ld_data),
        .raddr(key_q.addr[MEM_AW-1:0]),
        .rdata(rdata)
    );

    rom_lane_mux u_mux (
        .clk  (clk),
        .rst  (rst),
        .rdata(rdata),
        .id   (key_q.id),
        .a0   (key_q.addr[0]),
        .lsb  (key_q.lsb),
        .lo_ok(lo_valid),
        .hi_ok(hi_valid),
        .q    (q_out)
    );

    assert_drive_on_select_R3: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n) |=> (q_drv[7:0] == 8'hFF));
    assert_valid_implies_drive_R1: assert property (@(posedge clk) disable iff (rst)
        (lo_valid || hi_valid) |-> (q_drv[7:0] == 8'hFF));
    assert_deselect_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> (!lo_valid && !hi_valid));
    assert_narrow_upper_off_R2: assert property (@(posedge clk) disable iff (rst)
        !word_sel |=> (q_drv[15:8] == 8'h00 && !hi_valid));
    assert_gate_sampled_R6: assert property (@(posedge clk) disable iff (rst)
        lo_valid |-> $past(!oe_n && !ce_n));
    assert_id_code_R10: assert property (@(posedge clk) disable iff (rst)
        (lo_valid && $past(id_mode)) |-> (q_out[7:0] == id_code($past(addr[0]))));
endmodule

// File: tb/test_byteword_rom_port.sv
`timescale 1ns/1ps
module test_byteword_rom_port;
    localparam int ACC   = 100;
    localparam int OEC   = 50;
    localparam int BYTEC = 100;
    localparam int FLT   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [19:0] addr = '0;
    logic        lsb_in = 1'b0;
    logic        word_sel = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        id_mode = 1'b0;
    logic [15:0] q_out, q_drv;
    logic        lo_valid, hi_valid;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    byteword_rom_port #(.MEM_WORDS(256), .ACC_CYC(ACC), .OE_CYC(OEC),
                        .BYTE_CYC(BYTEC), .FLOAT_CYC(FLT)) i_byteword_rom_port (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .addr(addr), .lsb_in(lsb_in), .word_sel(word_sel), .ce_n(ce_n), .oe_n(oe_n),
        .id_mode(id_mode), .q_out(q_out), .q_drv(q_drv),
        .lo_valid(lo_valid), .hi_valid(hi_valid)
    );

    function automatic logic [15:0] pat(input logic [7:0] i);
        return {i ^ 8'hC3, i + 8'h11};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // which: 0 = lo_valid high, 1 = hi_valid high, 2 = all lanes undriven
    task automatic count_until(input int which, output int n);
        bit hit;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            hit = (which == 0) ? lo_valid : (which == 1) ? hi_valid : (q_drv == 16'h0);
        end while (!hit && n < 1000);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(q_drv == 16'h0, "R4 reset drive", q_drv, 0);
        check(!lo_valid && !hi_valid, "R4 reset valid", {lo_valid, hi_valid}, 0);
        check(q_out == 16'h0, "R4 reset data", q_out, 0);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) begin
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = pat(8'(i));
            @(negedge clk);
        end
        ld_we = 1'b0;
    endtask

    task automatic t_word;
        int n;
        word_sel = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 20'h3;
        @(posedge clk); @(negedge clk);
        check(q_drv == 16'hFFFF, "R3 drive after select", q_drv, 16'hFFFF);
        count_until(0, n);
        check(q_out == pat(8'h03), "R1 word data", q_out, pat(8'h03));
        addr = 20'h12;
        count_until(0, n);
        check(n == ACC, "R5 address access cycles", n, ACC);
        check(q_out == pat(8'h12), "R1 word data 0x12", q_out, pat(8'h12));
        check(hi_valid && q_drv == 16'hFFFF, "R1 upper valid and driven", {hi_valid, q_drv}, 32'h1FFFF);
    endtask

    task automatic t_oe;
        int n;
        oe_n = 1'b1;
        repeat (FLT + 2) @(posedge clk);
        @(negedge clk);
        check(q_drv == 16'h0 && !lo_valid, "R3 gate high no drive", q_drv, 0);
        oe_n = 1'b0;
        count_until(0, n);
        check(n == OEC, "R6 gate access cycles", n, OEC);
        check(q_out == pat(8'h12), "R6 data after gate", q_out, pat(8'h12));
    endtask

    task automatic t_ce;
        int n;
        ce_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!lo_valid && !hi_valid, "R8 valid drops", {lo_valid, hi_valid}, 0);
        check(q_drv == 16'hFFFF, "R8 still floating", q_drv, 16'hFFFF);
        count_until(2, n);
        check(n + 1 == FLT, "R8 float cycles", n + 1, FLT);
        oe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(q_drv == 16'h0, "R4 standby gate high", q_drv, 0);
        oe_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(q_drv == 16'h0 && !lo_valid, "R4 standby gate low", q_drv, 0);
        ce_n = 1'b0;
        count_until(0, n);
        check(n == ACC, "R7 chip select access cycles", n, ACC);
    endtask

    task automatic t_hold;
        int n;
        addr = 20'h1A;
        @(posedge clk); @(negedge clk);
        check(q_out == pat(8'h12) && !lo_valid, "R9 old data held", q_out, pat(8'h12));
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(q_out == pat(8'h12), "R9 old data still held", q_out, pat(8'h12));
        count_until(0, n);
        check(q_out == pat(8'h1A), "R1 new data after hold", q_out, pat(8'h1A));
    endtask

    task automatic t_byte;
        int n;
        logic [15:0] w;
        w = pat(8'h21);
        word_sel = 1'b0; lsb_in = 1'b0; addr = 20'h21;
        count_until(0, n);
        check(q_out[7:0] == w[7:0], "R2 low half", q_out[7:0], w[7:0]);
        check(q_drv == 16'h00FF && !hi_valid, "R2 upper lanes off", {hi_valid, q_drv}, 16'h00FF);
        lsb_in = 1'b1;
        count_until(0, n);
        check(n == ACC, "R5 extra bit counts as address", n, ACC);
        check(q_out[7:0] == w[15:8], "R2 high half", q_out[7:0], w[15:8]);
    endtask

    task automatic t_widen;
        int n;
        bit kept;
        lsb_in = 1'b0;
        count_until(0, n);
        word_sel = 1'b1;
        kept = 1'b1; n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
            if (!lo_valid) kept = 1'b0;
        end while (!hi_valid && n < 1000);
        check(kept, "R12 low lanes stay valid", kept, 1);
        check(n == BYTEC, "R12 widen delay", n, BYTEC);
        check(q_out == pat(8'h21), "R12 full word after widen", q_out, pat(8'h21));
        word_sel = 1'b0; lsb_in = 1'b1;
        count_until(0, n);
        word_sel = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!lo_valid, "R12 high half widen restarts", lo_valid, 0);
        count_until(0, n);
        check(n + 1 == ACC, "R12 restart cycles", n + 1, ACC);
        check(hi_valid && q_out == pat(8'h21), "R12 word after restart", q_out, pat(8'h21));
    endtask

    task automatic t_ident;
        int n;
        lsb_in = 1'b0; id_mode = 1'b1; addr = 20'h0;
        count_until(0, n);
        // pat(0) is 0xC311, so 0x0020 proves the code wins over the array
        check(q_out == 16'h0020, "R10 maker code", q_out, 16'h0020);
        addr = 20'h1;
        count_until(0, n);
        check(n == ACC, "R10 code switch cycles", n, ACC);
        check(q_out == 16'h00B1, "R10 part code", q_out, 16'h00B1);
    endtask

    task automatic t_ignore;
        int n;
        addr = 20'hABCD1; lsb_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(lo_valid && q_out == 16'h00B1, "R11 upper bits ignored", q_out, 16'h00B1);
        addr = 20'h5F00F;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(lo_valid && q_out == 16'h00B1, "R11 still ignored", q_out, 16'h00B1);
        id_mode = 1'b0; lsb_in = 1'b0; addr = 20'h5;
        count_until(0, n);
        check(n == ACC, "R10 leaving code mode cycles", n, ACC);
        check(q_out == pat(8'h05), "R10 array after code mode", q_out, pat(8'h05));
    endtask

    task automatic t_alias;
        int n;
        addr = 20'h01007;
        count_until(0, n);
        check(q_out == pat(8'h07), "R13 high address bits alias", q_out, pat(8'h07));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        t_word;
        t_oe;
        t_ce;
        t_hold;
        t_byte;
        t_widen;
        t_ident;
        t_ignore;
        t_alias;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule